// File: doc/BRIEF.md
# Non-Destructive Burst Memory Self-Test Controller

This controller tests a single-port synchronous SRAM while the system is running. When testing is enabled it asks the functional arbiter for the memory, and once the grant arrives it runs one short burst on a small window of consecutive addresses. A burst first copies the window into a local buffer. It then writes a checkerboard pattern and reads it back, writes the inverted pattern and reads that back, and finally writes the buffered words home before it lets go of the memory. Each later burst moves on to the next window, so the whole array is covered over many bursts and the functional contents survive.

A second mode claims the memory for one uninterrupted pass over every address. This mode has no copy and no restore, and it leaves the inverted pattern behind. A compare mismatch in either mode sets a sticky failure flag and records the address and the data read at the first mismatch. A one-cycle pulse marks the end of each full pass over the array.

Top module: `mbist_burst_ctrl`

## Requirements
- R1: The request output rises the cycle after the test enable is seen high in idle. No memory access is issued until grant has been sampled high while requesting, and the first access comes in the cycle after that sample.
- R2: A non-destructive burst on window base B of WIN words takes exactly 6*WIN consecutive access cycles, with index i running 0..WIN-1 in each phase. The phases are: read B+i, write pattern, read, write inverse pattern, read, write saved word. Request drops in the cycle after the last write.
- R3: The first burst after reset uses base 0. Each non-destructive burst then moves the base up by WIN, and after the window at DEPTH-WIN the base wraps to 0.
- R4: When a non-destructive burst ends, every word of its window holds the value it had when the burst was granted, and this also holds after a compare failure.
- R5: With the mode input high when grant is accepted, the burst covers addresses 0..DEPTH-1 in four phases (write pattern, read, write inverse, read), 4*DEPTH cycles with request held throughout. It does no copy and no restore, the array is left holding the inverse pattern, and the next window base is 0.
- R6: The pattern word for address a has bit k equal to 1 when k is even and 0 when k is odd, all bits inverted when a is odd. The second write phase uses the bitwise inverse of that word.
- R7: A read whose data differs from the expected pattern sets the failure flag, which stays set until reset. The flag becomes visible two cycles after the read access, and address and read data are captured only for the first mismatch.
- R8: The pass-complete output is a one-cycle pulse in the cycle after the last access of the burst that tested window DEPTH-WIN, or of a destructive pass, and is 0 at all other times.
- R9: After reset the request, access, pass-complete and failure outputs, the captured address and the captured data are all 0.
- R10: With the test enable low when a burst ends, no new request is raised and no access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_en_i | input | 1 | Allow new bursts to be requested |
| destr_mode_i | input | 1 | Select full destructive pass, sampled at grant |
| req_o | output | 1 | Memory access request to the arbiter |
| gnt_i | input | 1 | Grant, held until request drops |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after a read |
| pass_done_o | output | 1 | Pulse at end of a full pass |
| fail_o | output | 1 | Sticky compare failure |
| fail_addr_o | output | AW | Address of first mismatch |
| fail_data_o | output | DW | Data read at first mismatch |

## Verification
The bench builds the controller with AW=4, DW=8 and WIN=4. That gives a 16-word array split into four windows, so window wrap, repeated passes and the pass pulse come up within a few hundred cycles, and a full destructive pass is only 64 accesses long. The narrow word lets the bench model one faulty cell that flips a bit only when it holds the inverse pattern. Because the fault leaves saved data intact, a failing burst can be checked for a correct restore, and a second fault in a later window can be checked against the first capture.

// File: rtl/mbist_burst_pkg.sv
package mbist_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SAVE,
        ST_WPAT,
        ST_RPAT,
        ST_WINV,
        ST_RINV,
        ST_REST
    } mb_state_e;

    function automatic logic is_access(mb_state_e s);
        return s inside {ST_SAVE, ST_WPAT, ST_RPAT, ST_WINV, ST_RINV, ST_REST};
    endfunction

    function automatic logic is_write(mb_state_e s);
        return s inside {ST_WPAT, ST_WINV, ST_REST};
    endfunction

    function automatic logic is_check(mb_state_e s);
        return s inside {ST_RPAT, ST_RINV};
    endfunction

endpackage

// File: rtl/mbist_pattern_gen.sv
// Checkerboard word: even bits set, flipped for odd addresses and for the inverse phase.
module mbist_pattern_gen #(
    parameter int DW = 16
) (
    input  logic          addr_lsb_i,
    input  logic          inv_i,
    output logic [DW-1:0] data_o
);
    logic flip;
    assign flip = addr_lsb_i ^ inv_i;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        localparam logic EVEN = ((b % 2) == 0);
        assign data_o[b] = EVEN ^ flip;
    end
endmodule

// File: rtl/mbist_save_buf.sv
// Holds the original words of the current window until restore.
module mbist_save_buf #(
    parameter  int WIN = 4,
    parameter  int DW  = 16,
    localparam int IW  = $clog2(WIN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o
);
    logic [WIN-1:0][DW-1:0] slots;

    for (genvar s = 0; s < WIN; s++) begin : g_slot
        logic [DW-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en_i && (wr_idx_i == IW'(s))) slot_d = wr_data_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) slot_q <= '0;
            else         slot_q <= slot_d;
        end

        assign slots[s] = slot_q;
    end

    assign rd_data_o = slots[rd_idx_i];
endmodule

// File: rtl/mbist_win_ptr.sv
// Base address of the next window; steps by WIN and wraps to zero.
module mbist_win_ptr #(
    parameter int AW  = 6,
    parameter int WIN = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    input  logic          clr_i,
    output logic [AW-1:0] base_o,
    output logic          last_o
);
    localparam int            DEPTH     = 1 << AW;
    localparam logic [AW-1:0] LAST_BASE = AW'(DEPTH - WIN);
    localparam logic [AW-1:0] STEP      = AW'(WIN);

    logic [AW-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (clr_i)      base_d = '0;
        else if (adv_i) base_d = (base_q == LAST_BASE) ? '0 : base_q + STEP;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) base_q <= '0;
        else         base_q <= base_d;
    end

    assign base_o = base_q;
    assign last_o = (base_q == LAST_BASE);
endmodule

// File: rtl/mbist_cmp.sv
// One-cycle-delayed compare of read data and sticky first-failure capture.
module mbist_cmp #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          chk_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] exp_i,
    input  logic [DW-1:0] rdata_i,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o,
    output logic [DW-1:0] fail_data_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
        logic          fail;
        logic [AW-1:0] faddr;
        logic [DW-1:0] fdata;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.vld  = chk_i;
        c_d.addr = addr_i;
        c_d.exp  = exp_i;
        if (c_q.vld && (rdata_i != c_q.exp) && !c_q.fail) begin
            c_d.fail  = 1'b1;
            c_d.faddr = c_q.addr;
            c_d.fdata = rdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign fail_o      = c_q.fail;
    assign fail_addr_o = c_q.faddr;
    assign fail_data_o = c_q.fdata;
endmodule

// File: rtl/mbist_burst_ctrl.sv
module mbist_burst_ctrl
    import mbist_burst_pkg::*;
#(
    parameter int AW  = 6,
    parameter int DW  = 16,
    parameter int WIN = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          test_en_i,
    input  logic          destr_mode_i,
    output logic          req_o,
    input  logic          gnt_i,
    output logic          mem_en_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          pass_done_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o,
    output logic [DW-1:0] fail_data_o
);
    localparam int            DEPTH    = 1 << AW;
    localparam int            IW       = $clog2(WIN);
    localparam logic [AW:0]   LAST_ALL = (AW+1)'(DEPTH - 1);
    localparam logic [AW:0]   LAST_WIN = (AW+1)'(WIN - 1);

    typedef struct packed {
        mb_state_e     st;
        logic [AW:0]   idx;
        logic          destr;
        logic          done;
        logic          sv_vld;
        logic [IW-1:0] sv_idx;
    } ctl_t;

    ctl_t r_d, r_q;

    logic          acc, wr, chk, inv, at_end;
    logic          ptr_adv, ptr_clr, win_last;
    logic [AW-1:0] win_base, eff_base, cur_addr;
    logic [DW-1:0] pat_word, buf_word;

    mbist_win_ptr #(.AW(AW), .WIN(WIN)) u_ptr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (ptr_adv),
        .clr_i  (ptr_clr),
        .base_o (win_base),
        .last_o (win_last)
    );

    mbist_pattern_gen #(.DW(DW)) u_pat (
        .addr_lsb_i (cur_addr[0]),
        .inv_i      (inv),
        .data_o     (pat_word)
    );

    mbist_save_buf #(.WIN(WIN), .DW(DW)) u_buf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (r_q.sv_vld),
        .wr_idx_i  (r_q.sv_idx),
        .wr_data_i (mem_rdata_i),
        .rd_idx_i  (r_q.idx[IW-1:0]),
        .rd_data_o (buf_word)
    );

    mbist_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .chk_i       (chk),
        .addr_i      (cur_addr),
        .exp_i       (pat_word),
        .rdata_i     (mem_rdata_i),
        .fail_o      (fail_o),
        .fail_addr_o (fail_addr_o),
        .fail_data_o (fail_data_o)
    );

    // Datapath decode of the current phase.
    always_comb begin
        acc      = is_access(r_q.st);
        wr       = is_write(r_q.st);
        chk      = is_check(r_q.st);
        inv      = (r_q.st == ST_WINV) || (r_q.st == ST_RINV);
        eff_base = r_q.destr ? '0 : win_base;
        cur_addr = eff_base + r_q.idx[AW-1:0];
        at_end   = (r_q.idx == (r_q.destr ? LAST_ALL : LAST_WIN));
    end

    // Sequencer next-state.
    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.sv_vld = (r_q.st == ST_SAVE);
        r_d.sv_idx = r_q.idx[IW-1:0];
        ptr_adv    = 1'b0;
        ptr_clr    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (test_en_i) r_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (gnt_i) begin
                    r_d.destr = destr_mode_i;
                    r_d.idx   = '0;
                    r_d.st    = destr_mode_i ? ST_WPAT : ST_SAVE;
                end
            end
            default: begin
                if (!at_end) begin
                    r_d.idx = r_q.idx + 1'b1;
                end else begin
                    r_d.idx = '0;
                    unique case (r_q.st)
                        ST_SAVE: r_d.st = ST_WPAT;
                        ST_WPAT: r_d.st = ST_RPAT;
                        ST_RPAT: r_d.st = ST_WINV;
                        ST_WINV: r_d.st = ST_RINV;
                        ST_RINV: begin
                            if (r_q.destr) begin
                                r_d.st   = ST_IDLE;
                                r_d.done = 1'b1;
                                ptr_clr  = 1'b1;
                            end else begin
                                r_d.st = ST_REST;
                            end
                        end
                        ST_REST: begin
                            r_d.st   = ST_IDLE;
                            r_d.done = win_last;
                            ptr_adv  = 1'b1;
                        end
                        default: r_d.st = ST_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o       = (r_q.st != ST_IDLE);
    assign mem_en_o    = acc;
    assign mem_we_o    = wr;
    assign mem_addr_o  = acc ? cur_addr : '0;
    assign mem_wdata_o = !wr ? '0 : ((r_q.st == ST_REST) ? buf_word : pat_word);
    assign pass_done_o = r_q.done;
endmodule

// File: rtl/mbist_burst_chk.sv
module mbist_burst_chk #(
    parameter int AW  = 6,
    parameter int DW  = 16,
    parameter int WIN = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_i,
    input logic          gnt_i,
    input logic          mem_en_i,
    input logic          mem_we_i,
    input logic          dmode_i,
    input logic          pass_done_i,
    input logic          fail_i,
    input logic [AW-1:0] fail_addr_i,
    input logic [DW-1:0] fail_data_i
);
    localparam logic [15:0] BURST = 16'(6 * WIN);

    logic [15:0] len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       len_q <= '0;
        else if (!req_i)   len_q <= '0;
        else if (mem_en_i) len_q <= len_q + 16'd1;
    end

    a_r1_access_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_en_i |-> gnt_i);

    a_r10_no_access_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |-> !mem_en_i);

    a_r2_burst_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && mem_en_i && !dmode_i) |-> (len_q < BURST));

    a_r5_destr_starts_writing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dmode_i && $rose(mem_en_i)) |-> mem_we_i);

    a_r7_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |=> (fail_i && $stable(fail_addr_i) && $stable(fail_data_i)));

    a_r8_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_done_i |=> !pass_done_i);

    a_r8_done_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_done_i |-> !mem_en_i);
endmodule

bind mbist_burst_ctrl mbist_burst_chk #(.AW(AW), .DW(DW), .WIN(WIN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_o),
    .gnt_i       (gnt_i),
    .mem_en_i    (mem_en_o),
    .mem_we_i    (mem_we_o),
    .dmode_i     (r_q.destr),
    .pass_done_i (pass_done_o),
    .fail_i      (fail_o),
    .fail_addr_i (fail_addr_o),
    .fail_data_i (fail_data_o)
);

// File: tb/mbist_burst_ctrl_bench.sv
module mbist_burst_ctrl_bench;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int WIN   = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NWIN  = DEPTH / WIN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic          destr_mode = 1'b0;
    logic          req, gnt, mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          pass_done, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_data;

    always #2 clk = ~clk;  // 250 MHz

    mbist_burst_ctrl #(.AW(AW), .DW(DW), .WIN(WIN)) u_mbist_burst_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .test_en_i(test_en), .destr_mode_i(destr_mode),
        .req_o(req), .gnt_i(gnt), .mem_en_o(mem_en), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .pass_done_o(pass_done), .fail_o(fail), .fail_addr_o(fail_addr), .fail_data_o(fail_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input bit inv);
        logic [DW-1:0] p;
        for (int k = 0; k < DW; k++) p[k] = ((k % 2) == 0);
        if ((a % 2) == 1) p = ~p;
        if (inv) p = ~p;
        return p;
    endfunction

    // Memory with one optional faulty cell: reads flip bit 0 while it holds the inverse pattern.
    logic [DW-1:0] mem [DEPTH];
    bit            inj_on = 0;
    int            inj_addr = 0;
    logic          fw_en = 1'b0;
    logic [AW-1:0] fw_addr = '0;
    logic [DW-1:0] fw_data = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else if (inj_on && int'(mem_addr) == inj_addr && mem[mem_addr] == pat(int'(mem_addr), 1'b1))
                mem_rdata <= mem[mem_addr] ^ DW'(1);
            else
                mem_rdata <= mem[mem_addr];
        end else if (fw_en && !gnt) begin
            mem[fw_addr] <= fw_data;
        end
    end

    // Arbiter: functional side busy part of the time; grant held while requested.
    int busy_cnt = 0;
    always @(posedge clk) begin
        busy_cnt <= busy_cnt + 1;
        if (!rst_n) gnt <= 1'b0;
        else        gnt <= req && (gnt || ((busy_cnt % 5) >= 2));
    end

    // Behavioural reference model.
    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
    } op_t;

    op_t           exp_q[$];
    logic [DW-1:0] snap [DEPTH];
    int            m_base = 0;
    bit            m_destr = 0;
    bit            m_done = 0;
    bit            m_fail = 0;
    int            m_faddr = 0;
    logic [DW-1:0] m_fdata = '0;
    bit            rel_next = 0;
    bit            fchk_next = 0;
    bit            run_chk = 0;
    int            bursts_done = 0;

    task automatic push_burst();
        int b, n;
        bit dm;
        dm = destr_mode;
        b  = dm ? 0 : m_base;
        n  = dm ? DEPTH : WIN;
        for (int a = 0; a < DEPTH; a++) snap[a] = mem[a];
        if (!dm) for (int i = 0; i < n; i++) exp_q.push_back({1'b0, AW'(b+i), DW'(0)});
        for (int i = 0; i < n; i++) exp_q.push_back({1'b1, AW'(b+i), pat(b+i, 1'b0)});
        for (int i = 0; i < n; i++) exp_q.push_back({1'b0, AW'(b+i), DW'(0)});
        for (int i = 0; i < n; i++) exp_q.push_back({1'b1, AW'(b+i), pat(b+i, 1'b1)});
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b0, AW'(b+i), DW'(0)});
            if (inj_on && (b+i) == inj_addr && !m_fail) begin
                m_fail  = 1;
                m_faddr = b + i;
                m_fdata = pat(b+i, 1'b1) ^ DW'(1);
            end
        end
        if (!dm) for (int i = 0; i < n; i++) exp_q.push_back({1'b1, AW'(b+i), snap[b+i]});
        m_destr = dm;
        m_done  = dm ? 1'b1 : (m_base == DEPTH - WIN);
        m_base  = dm ? 0 : (m_base + WIN) % DEPTH;
    endtask

    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            if (exp_q.size() > 0) begin
                op_t op;
                op = exp_q.pop_front();
                check("R2 access enable", 32'(mem_en), 32'd1);
                check("R5 request held", 32'(req), 32'd1);
                check("R2 write enable", 32'(mem_we), 32'(op.we));
                check("R3 address", 32'(mem_addr), 32'(op.addr));
                if (op.we) check("R6 R4 write data", 32'(mem_wdata), 32'(op.wd));
                if (exp_q.size() == 0) rel_next = 1;
            end else if (rel_next) begin
                rel_next = 0;
                check("R2 request released", 32'(req), 32'd0);
                check("R2 no access at release", 32'(mem_en), 32'd0);
                check("R8 pass pulse", 32'(pass_done), 32'(m_done));
                if (!m_destr)
                    for (int a = 0; a < DEPTH; a++) check("R4 contents kept", 32'(mem[a]), 32'(snap[a]));
                bursts_done++;
                fchk_next = 1;
            end else begin
                check("R1 no access before grant", 32'(mem_en), 32'd0);
                check("R8 no stray pulse", 32'(pass_done), 32'd0);
                if (fchk_next) begin
                    fchk_next = 0;
                    check("R7 fail flag", 32'(fail), 32'(m_fail));
                    if (m_fail) begin
                        check("R7 fail address", 32'(fail_addr), 32'(m_faddr));
                        check("R7 fail data", 32'(fail_data), 32'(m_fdata));
                    end
                end
                if (req && gnt) push_burst();
            end
        end
    end

    task automatic fwrite(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        fw_en = 1'b1; fw_addr = AW'(a); fw_data = d;
        @(negedge clk);
        fw_en = 1'b0;
    endtask

    function automatic logic [DW-1:0] safe_val(input int a, input int salt);
        logic [DW-1:0] v;
        v = DW'(a * 29 + salt);
        if (v == pat(a, 1'b1)) v = v ^ DW'(2);
        return v;
    endfunction

    task automatic run_bursts(input int n);
        int target;
        target = bursts_done + n;
        test_en = 1'b1;
        wait (bursts_done >= target);
        test_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 req", 32'(req), 32'd0);
        check("R9 mem_en", 32'(mem_en), 32'd0);
        check("R9 pass_done", 32'(pass_done), 32'd0);
        check("R9 fail", 32'(fail), 32'd0);
        check("R9 fail_addr", 32'(fail_addr), 32'd0);
        check("R9 fail_data", 32'(fail_data), 32'd0);
        for (int a = 0; a < DEPTH; a++) fwrite(a, safe_val(a, 7));
        run_chk = 1;

        // R3 R8: two full passes over the array
        run_bursts(2 * NWIN);

        // R10: enable low keeps the controller quiet
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            check("R10 no request", 32'(req), 32'd0);
        end

        fwrite(5, safe_val(5, 91));
        fwrite(14, safe_val(14, 33));
        run_bursts(NWIN);
        check("R7 no fail on good array", 32'(fail), 32'd0);

        // R7 R4: faulty cell, restore still happens
        inj_on = 1; inj_addr = 6;
        run_bursts(NWIN);
        check("R7 fail set", 32'(fail), 32'd1);
        check("R7 first address", 32'(fail_addr), 32'd6);
        check("R7 first data", 32'(fail_data), 32'(pat(6, 1'b1) ^ DW'(1)));

        inj_addr = 13;
        run_bursts(NWIN);
        check("R7 sticky address", 32'(fail_addr), 32'd6);
        check("R7 sticky flag", 32'(fail), 32'd1);
        inj_on = 0;

        // R5 destructive pass
        destr_mode = 1'b1;
        run_bursts(1);
        destr_mode = 1'b0;
        for (int a = 0; a < DEPTH; a++) check("R5 inverse left", 32'(mem[a]), 32'(pat(a, 1'b1)));

        // R5: next window base back at zero (address check in model)
        run_bursts(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule